// File: doc/BRIEF.md
# 128-by-64 Quotient Estimator

This block produces a fast 64-bit estimate of the quotient of a 128-bit dividend by a 64-bit divisor. It is meant for the normalise-and-round path of a floating-point divider, where a later exact step corrects the last few units. The estimate may be slightly larger than the true quotient, but it is never smaller.

The estimate is built as two 32-bit digits. Each digit is found by dividing a 64-bit value by the divisor's upper 32 bits, using a 32-step restoring sub-divider. After the upper digit, the block forms the full 128-bit product of divisor and estimate and subtracts it from the dividend. If the partial remainder is negative, it repeatedly lowers the upper digit by one and adds the shifted divisor back. It then takes the middle 64 bits of the remainder and divides them again to get the lower digit. A dividend whose upper half is not below the divisor saturates the result at once.

The caller pulses `start` with the operands while the unit is idle. It reads `quotient` in the cycle where `done` is high.

Top module: `quotEst128`

## Requirements
- R1: After reset, `busy`, `done` and `quotient` are all zero.
- R2: A `start` pulse seen while `busy` is low is accepted, and `busy` is high in the following cycle.
- R3: A `start` pulse seen while `busy` is high is ignored. The running operation finishes with the result for its own operands, and no extra `done` pulse follows.
- R4: `done` is high for exactly one cycle per accepted operation. In the cycle after `done`, `busy` is low.
- R5: When the dividend's upper 64 bits are greater than or equal to the divisor, the result is all ones (0xFFFFFFFFFFFFFFFF).
- R6: When the divisor's upper 32 bits, moved to the top of a 64-bit word, do not exceed the dividend's upper 64 bits, the upper digit starts at all ones. The result then follows the same correction and lower-digit steps.
- R7: For any dividend whose upper half is below a divisor that has bit 63 set, the result equals the two-digit estimate described below. The upper digit is the dividend's upper half divided by the divisor's top 32 bits. The 128-bit remainder is then corrected by subtracting 2^32 and adding back the divisor shifted left by 32, for as long as bit 127 is set. The lower digit is remainder bits 95:32 divided by the divisor's top 32 bits, or all ones when those bits are not below the top 32 bits shifted up by 32.
- R8: For such a normalised divisor, the result lies between the floor of the true quotient and that floor plus 2.
- R9: `quotient` keeps its value from the `done` cycle until the next accepted operation writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an estimate with the operands on the data inputs |
| dividendHi | input | 64 | Upper 64 bits of the dividend |
| dividendLo | input | 64 | Lower 64 bits of the dividend |
| divisor | input | 64 | Divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: `quotient` holds the new estimate |
| quotient | output | 64 | Quotient estimate |

## Verification
The assertions assume the operands stay valid only in the cycle `start` is sampled, and that the divisor is non-zero. The correction loop runs one cycle per step, so the assertions also assume its iteration count stays small. That holds when the divisor has bit 63 set, or when saturation applies. With a small but non-zero upper divisor half, the count can reach billions of cycles. The random stimulus therefore draws divisors with the top bit set and upper dividend halves reduced modulo the divisor. Small divisors appear only in directed cases that saturate.

// File: rtl/qe_pkg.sv
package qe_pkg;

  // Strobes from the sequencer to the datapath, at most one action group per cycle.
  typedef struct packed {
    logic loadIn;     // capture operands into the remainder and divisor registers
    logic estSat;     // estimate := all ones
    logic estHiOnes;  // upper digit := all ones
    logic estHiDiv;   // upper digit := sub-divider result
    logic mulSub;     // remainder -= divisor * estimate
    logic fixStep;    // estimate -= 2^32, remainder += shifted divisor
    logic realign;    // remainder high := middle 64 bits
    logic estLoOnes;  // lower digit := all ones
    logic estLoDiv;   // lower digit := sub-divider result
    logic divGo;      // launch the digit sub-divider
  } qeStrobe_t;

  // Conditions from the datapath to the sequencer.
  typedef struct packed {
    logic hiSat;    // remainder high >= divisor
    logic topBig;   // (divisor top half << half) <= remainder high
    logic remNeg;   // remainder sign bit
    logic digDone;  // sub-divider finished
  } qeStatus_t;

endpackage

// File: rtl/mulWide.sv
module mulWide #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prodHi,
  output logic [W-1:0] prodLo
);
  localparam int H = W / 2;

  logic [W-1:0] pLL, pLH, pHL, pHH;
  logic [W:0]   midSum;
  logic [W-1:0] lowPart;
  logic         lowCarry;

  always_comb begin
    pLL = W'(a[H-1:0]) * W'(b[H-1:0]);
    pLH = W'(a[H-1:0]) * W'(b[W-1:H]);
    pHL = W'(a[W-1:H]) * W'(b[H-1:0]);
    pHH = W'(a[W-1:H]) * W'(b[W-1:H]);
    midSum   = {1'b0, pLH} + {1'b0, pHL};
    lowPart  = pLL + {midSum[H-1:0], {H{1'b0}}};
    lowCarry = (lowPart < pLL);
    prodLo   = lowPart;
    prodHi   = pHH + {{(H-1){1'b0}}, midSum[W], midSum[W-1:H]} + W'(lowCarry);
  end
endmodule

// File: rtl/digitDiv.sv
module digitDiv #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            go,
  input  logic [2*DW-1:0] num,
  input  logic [DW-1:0]   den,
  output logic            done,
  output logic [DW-1:0]   quot
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] rem, lowBits, denR;
  logic [CW-1:0] cnt;
  logic          running;
  logic [DW:0]   trial;
  logic          fits;

  always_comb begin
    trial = {rem, lowBits[DW-1]};
    fits  = (trial >= {1'b0, denR});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem     <= '0;
      lowBits <= '0;
      denR    <= '0;
      quot    <= '0;
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem     <= num[2*DW-1:DW];
        lowBits <= num[DW-1:0];
        denR    <= den;
        quot    <= '0;
        cnt     <= CW'(DW);
        running <= 1'b1;
      end else if (running) begin
        rem     <= fits ? DW'(trial - {1'b0, denR}) : trial[DW-1:0];
        lowBits <= {lowBits[DW-2:0], 1'b0};
        quot    <= {quot[DW-2:0], fits};
        cnt     <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qeDatapath.sv
module qeDatapath
  import qe_pkg::*;
#(
  parameter int W = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  qeStrobe_t  stb,
  input  logic [W-1:0] inHi,
  input  logic [W-1:0] inLo,
  input  logic [W-1:0] inDiv,
  output qeStatus_t  sts,
  output logic [W-1:0] estOut
);
  localparam int H = W / 2;

  logic [W-1:0] remH, remL, dvs, est;
  logic [W-1:0] prodHi, prodLo;
  logic [W-1:0] subLo, subHi, addLo, addHi;
  logic         borrow, carry;
  logic [H-1:0] digit;
  logic         digDone;

  mulWide #(.W(W)) u_mul (
    .a(dvs), .b(est), .prodHi(prodHi), .prodLo(prodLo)
  );

  digitDiv #(.DW(H)) u_div (
    .clk(clk), .rstN(rstN), .go(stb.divGo),
    .num(remH), .den(dvs[W-1:H]),
    .done(digDone), .quot(digit)
  );

  always_comb begin
    subLo  = remL - prodLo;
    borrow = (remL < prodLo);
    subHi  = remH - prodHi - W'(borrow);
    addLo  = remL + {dvs[H-1:0], {H{1'b0}}};
    carry  = (addLo < remL);
    addHi  = remH + W'(dvs[W-1:H]) + W'(carry);
    sts.hiSat   = (remH >= dvs);
    sts.topBig  = ({dvs[W-1:H], {H{1'b0}}} <= remH);
    sts.remNeg  = remH[W-1];
    sts.digDone = digDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remH <= '0;
      remL <= '0;
      dvs  <= '0;
      est  <= '0;
    end else begin
      if (stb.loadIn) begin
        remH <= inHi;
        remL <= inLo;
        dvs  <= inDiv;
      end
      if (stb.estSat)    est <= '1;
      if (stb.estHiOnes) est <= {{H{1'b1}}, {H{1'b0}}};
      if (stb.estHiDiv)  est <= {digit, {H{1'b0}}};
      if (stb.mulSub) begin
        remH <= subHi;
        remL <= subLo;
      end
      if (stb.fixStep) begin
        est  <= est - {{(H-1){1'b0}}, 1'b1, {H{1'b0}}};
        remH <= addHi;
        remL <= addLo;
      end
      if (stb.realign)   remH <= {remH[H-1:0], remL[W-1:H]};
      if (stb.estLoOnes) est <= est | {{H{1'b0}}, {H{1'b1}}};
      if (stb.estLoDiv)  est <= est | {{H{1'b0}}, digit};
    end
  end

  assign estOut = est;
endmodule

// File: rtl/qeControl.sv
module qeControl
  import qe_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  qeStatus_t sts,
  output qeStrobe_t stb,
  output logic      busy,
  output logic      done
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_DIV1, S_MUL, S_FIX, S_LOCHK, S_DIV2, S_FIN
  } qeState_e;

  qeState_e state, nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        stb.loadIn = 1'b1;
        nextState  = S_CHECK;
      end
      S_CHECK: begin
        if (sts.hiSat) begin
          stb.estSat = 1'b1;
          nextState  = S_FIN;
        end else if (sts.topBig) begin
          stb.estHiOnes = 1'b1;
          nextState     = S_MUL;
        end else begin
          stb.divGo = 1'b1;
          nextState = S_DIV1;
        end
      end
      S_DIV1: if (sts.digDone) begin
        stb.estHiDiv = 1'b1;
        nextState    = S_MUL;
      end
      S_MUL: begin
        stb.mulSub = 1'b1;
        nextState  = S_FIX;
      end
      S_FIX: begin
        if (sts.remNeg) stb.fixStep = 1'b1;
        else begin
          stb.realign = 1'b1;
          nextState   = S_LOCHK;
        end
      end
      S_LOCHK: begin
        if (sts.topBig) begin
          stb.estLoOnes = 1'b1;
          nextState     = S_FIN;
        end else begin
          stb.divGo = 1'b1;
          nextState = S_DIV2;
        end
      end
      S_DIV2: if (sts.digDone) begin
        stb.estLoDiv = 1'b1;
        nextState    = S_FIN;
      end
      S_FIN: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
endmodule

// File: rtl/quotEst128.sv
module quotEst128
  import qe_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividendHi,
  input  logic [W-1:0] dividendLo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  qeStrobe_t stb;
  qeStatus_t sts;

  qeControl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .sts(sts),
    .stb(stb), .busy(busy), .done(done)
  );

  qeDatapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inHi(dividendHi), .inLo(dividendLo), .inDiv(divisor),
    .sts(sts), .estOut(quotient)
  );
endmodule

// File: rtl/quotEst128_chk.sv
module quotEst128_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [W-1:0] dividendHi,
  input logic [W-1:0] dividendLo,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient
);
  logic [W-1:0] capHi, capDv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capHi <= '0;
      capDv <= '0;
    end else if (start && !busy) begin
      capHi <= dividendHi;
      capDv <= divisor;
    end
  end

  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  a_r3_stay_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r4_idle_after: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (done && (capHi >= capDv)) |-> (quotient == {W{1'b1}}));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(quotient));
endmodule

bind quotEst128 quotEst128_chk #(.W(W)) u_chk (.*);

// File: tb/quotEst128_bench.sv
module quotEst128_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] dH = '0, dL = '0, dv = '0;
  logic        busy, done;
  logic [63:0] quotient;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;  // 250 MHz

  quotEst128 u_quotEst128 (
    .clk(clk), .rstN(rstN), .start(start),
    .dividendHi(dH), .dividendLo(dL), .divisor(dv),
    .busy(busy), .done(done), .quotient(quotient)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] refEst(input logic [63:0] nh, input logic [63:0] nl, input logic [63:0] m);
    logic [127:0] rem;
    logic [63:0]  z, mh, r;
    if (nh >= m) return '1;
    mh = m >> 32;
    if ((mh << 32) <= nh) z = 64'hFFFF_FFFF_0000_0000;
    else                  z = (nh / mh) << 32;
    rem = {nh, nl} - (128'(m) * 128'(z));
    for (int k = 0; k < 64 && rem[127]; k++) begin
      z   = z - 64'h1_0000_0000;
      rem = rem + (128'(m) << 32);
    end
    r = rem[95:32];
    if ((mh << 32) <= r) z = z | 64'h0000_0000_FFFF_FFFF;
    else                 z = z | (r / mh);
    return z;
  endfunction

  task automatic runOp(input logic [63:0] nh, input logic [63:0] nl, input logic [63:0] m,
                       input bit poke, output logic [63:0] got);
    int waited;
    @(negedge clk);
    start = 1'b1; dH = nh; dL = nl; dv = m;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    waited = 0;
    while (!done && waited < 3000) begin
      if (poke && waited == 3) begin
        start = 1'b1; dH = 64'd0; dL = 64'd1; dv = 64'd1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R4 done seen", 64'(done), 64'd1);
    got = quotient;
    @(negedge clk);
    chk(done == 1'b0, "R4 done one cycle", 64'(done), 64'd0);
    chk(busy == 1'b0, "R4 idle after done", 64'(busy), 64'd0);
  endtask

  task automatic checkRef(input logic [63:0] nh, input logic [63:0] nl, input logic [63:0] m, input string tag);
    logic [63:0] got, exp;
    runOp(nh, nl, m, 1'b0, got);
    exp = refEst(nh, nl, m);
    chk(got == exp, tag, got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [63:0] got, exp, m, nh, nl;
    logic [127:0] tq, num128;
    int seenDone;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // R1: reset values
    chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    chk(quotient == 64'd0, "R1 quotient", quotient, 64'd0);
    rstN = 1'b1;

    // R5: saturation cases
    runOp(64'h8000_0000_0000_0000, 64'h1234, 64'h8000_0000_0000_0000, 1'b0, got);
    chk(got == '1, "R5 equal high half", got, '1);
    runOp(64'hFFFF_0000_0000_0000, 64'h0, 64'h9000_0000_0000_0001, 1'b0, got);
    chk(got == '1, "R5 larger high half", got, '1);
    runOp(64'd7, 64'hFFFF, 64'd5, 1'b0, got);
    chk(got == '1, "R5 small divisor", got, '1);

    // R6: upper digit all-ones shortcut
    checkRef(64'h8000_0001_0000_0005, 64'hDEAD_BEEF_0000_0001, 64'h8000_0001_FFFF_FFFF, "R6 top shortcut");
    checkRef(64'hFFFF_FFFF_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 max divisor");

    // R7: directed exact and edge values
    checkRef(64'h0, 64'h0, 64'h8000_0000_0000_0000, "R7 zero dividend");
    checkRef(64'h4000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000, "R7 exact half");
    checkRef(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R7 largest below");

    // R9: quotient holds while idle
    exp = quotient;
    repeat (6) @(negedge clk);
    chk(quotient == exp, "R9 hold while idle", quotient, exp);

    // R3: start while busy is ignored
    m  = 64'hC000_0000_1234_5678;
    nh = 64'h1111_2222_3333_4444;
    nl = 64'h5555_6666_7777_8888;
    runOp(nh, nl, m, 1'b1, got);
    exp = refEst(nh, nl, m);
    chk(got == exp, "R3 result kept", got, exp);
    seenDone = 0;
    for (int c = 0; c < 120; c++) begin
      @(negedge clk);
      if (done) seenDone++;
    end
    chk(seenDone == 0, "R3 no extra done", 64'(seenDone), 64'd0);
    chk(quotient == exp, "R9 hold after done", quotient, exp);

    // R7/R8: random normalised divisors
    for (int i = 0; i < 150; i++) begin
      m  = {1'b1, 31'($urandom), $urandom};
      nh = {$urandom, $urandom} % m;
      nl = {$urandom, $urandom};
      runOp(nh, nl, m, 1'b0, got);
      exp = refEst(nh, nl, m);
      chk(got == exp, "R7 random estimate", got, exp);
      num128 = {nh, nl};
      tq = num128 / 128'(m);
      chk((128'(got) >= tq) && (128'(got) <= tq + 128'd2), "R8 bound", got, tq[63:0]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule